// File: doc/BRIEF.md
# Segmented Associative-Memory Host Port

This block is the host-facing command and data port of a 128-bit-wide associative memory whose host bus is only 32 bits wide. Each host transfer is one cycle, qualified by `cyc_vld`, with `cyc_wr` picking write or read and `cyc_cmd` picking a command cycle or a data cycle. Data cycles move one 32-bit segment of a 128-bit resource. The resource is chosen by a persistent selection, kept separately for reads (source) and writes (destination). Two segment counters step through the four segments on their own. The comparand and both mask registers are held in this block and driven out to the match logic. The memory array sits outside the block and is reached through a segment-wide array port.

Command writes carry an instruction in the upper 16 data bits. An instruction can change the persistent source or destination, switch the active configuration bank, or act as a one-shot override on a 16-bit register. With the address-field flag set, the override writes the register in the same cycle. With the flag clear, it arms the next command read to return that register. Command reads return the 32-bit status word when no override is armed.

Two small state machines carry the control state. The override machine has states OVR_IDLE and OVR_ARMED:
- OVR_IDLE goes to OVR_ARMED on an override instruction with the flag clear.
- OVR_ARMED goes to OVR_IDLE on the next command read, or on any other command write.
- A repeated arming instruction keeps the machine in OVR_ARMED with a new target.

The bank machine has states BANK_FG and BANK_BG. It moves between them on a bank-select instruction and starts in BANK_FG.

Top module: `cam_host_port`

## Requirements
- R1: After reset, the foreground bank is active and the comparand (code 0) is both the persistent source and the persistent destination in both banks. Both segment counters, all registers, `rdata`, `rd_vld` and `compare_trig` are 0.
- R2: A data write (`cyc_vld=1, cyc_wr=1, cyc_cmd=0`) to a register destination stores `wdata` into bits 32k+31..32k, where k is the destination counter. Segment 0 holds bits 31..0 and segment 3 holds bits 127..96. The counter then steps k to k+1 and wraps from 3 to 0.
- R3: A data read (`cyc_wr=0, cyc_cmd=0`) presents segment k of the persistent source on `rdata`, where k is the source counter, with `rd_vld` high in the following cycle. The source counter then advances and wraps from 3 to 0.
- R4: The instruction is `wdata[31:16]`, with its class in bits 31..28 and its target in bits 18..16. Class 1 selects the persistent source and class 2 selects the persistent destination. The target codes are 0 for the comparand, 1 for mask 1, 2 for mask 2 and 3 for the array. Each select changes only its own direction in the active bank and clears that direction's counter to 0.
- R5: Data cycles whose selected target is the array (code 3) do not touch the registers. A data write raises `arr_wr_en` in the same cycle, with `arr_wr_seg` and `arr_wdata`. A data read raises `arr_rd_en` with `arr_rd_seg` and returns `arr_rdata`. `arr_addr` is the active bank's address register.
- R6: A command read with no armed override returns all 32 bits of `status_in`.
- R7: Class 3 with the flag bit `wdata[27]` set writes `wdata[15:0]` into the register named by the target. The codes are 0 control, 1 page address, 2 segment control, 3 address and 5 device select. Control, segment control and address go to the active bank.
- R8: Class 3 with `wdata[27]` clear arms a one-shot read. The next command read returns `{status_in[31:16], reg}`, or `{16'h0, page}` for code 1. The other codes are 4 for the `nfa_in` value, 6 for the persistent source and 7 for the persistent destination. The override then lapses. Data cycles leave it armed, and any other command write cancels or replaces it.
- R9: Class 4 selects the background bank when bit 16 is 1 and the foreground bank when it is 0, and clears both segment counters. The control, segment control, address, mask 1 and source/destination selections are kept separately per bank.
- R10: `compare_trig` pulses for one cycle after a control-register write, or after a write to segment 3 of the comparand, mask 1 or mask 2. It stays low after any other cycle.
- R11: The following cycles change no register or selection: a class-3 write with the flag set and code 4, 6 or 7, and a command write of class 0 or of classes 5 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | Host cycle valid for this clock |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| wdata | input | 32 | Host write data / instruction |
| rdata | output | 32 | Read data, valid with rd_vld |
| rd_vld | output | 1 | Read result valid (one cycle after a read) |
| status_in | input | 32 | Status word from the match logic |
| nfa_in | input | 16 | Next-free address from the match logic |
| arr_addr | output | 16 | Active bank address register |
| arr_wr_en | output | 1 | Array segment write strobe |
| arr_wr_seg | output | 2 | Array segment being written |
| arr_wdata | output | 32 | Array segment write data |
| arr_rd_en | output | 1 | Array segment read strobe |
| arr_rd_seg | output | 2 | Array segment being read |
| arr_rdata | input | 32 | Array segment read data (same cycle) |
| cmp_data | output | 128 | Comparand register |
| msk1_data | output | 128 | Mask 1 of the active bank |
| msk2_data | output | 128 | Mask 2 register |
| ctrl_out | output | 16 | Control register of the active bank |
| compare_trig | output | 1 | One-cycle compare request |

## Verification
The stimulus mixes the following:
- Long runs of data writes and reads over all four targets. These tell apart the wrap of each counter, and which counter belongs to which direction.
- Select instructions placed mid-stream. These show that a select clears only its own counter.
- Bank switches between the selections. These expose any state that was wrongly shared between the banks.
- Override arming followed by data cycles and then a command read. This separates the one-shot read from the plain status read, and the page-address case with a zero upper half from the other registers.
- Writes to read-only codes and unused classes, followed by read-back. These show that nothing changed.

// File: rtl/cam_port_pkg.sv
package cam_port_pkg;

    localparam int CLS_W    = 4;
    localparam int FLAG_BIT = 11;

    typedef enum logic [1:0] {
        TGT_CMP  = 2'd0,
        TGT_MSK1 = 2'd1,
        TGT_MSK2 = 2'd2,
        TGT_ARR  = 2'd3
    } tgt_e;

    typedef enum logic [3:0] {
        OPC_NOP  = 4'd0,
        OPC_SPS  = 4'd1,
        OPC_SPD  = 4'd2,
        OPC_TCO  = 4'd3,
        OPC_BANK = 4'd4
    } opclass_e;

    typedef enum logic [2:0] {
        TCO_CTRL   = 3'd0,
        TCO_PAGE   = 3'd1,
        TCO_SEGCTL = 3'd2,
        TCO_ADDR   = 3'd3,
        TCO_NFA    = 3'd4,
        TCO_DEVSEL = 3'd5,
        TCO_PS     = 3'd6,
        TCO_PD     = 3'd7
    } tco_e;

    typedef enum logic {
        OVR_IDLE  = 1'b0,
        OVR_ARMED = 1'b1
    } ovr_state_e;

    typedef enum logic {
        BANK_FG = 1'b0,
        BANK_BG = 1'b1
    } bank_state_e;

    typedef struct packed {
        logic sel_src;
        logic sel_dst;
        logic tco_wr;
        logic tco_arm;
        logic bank_sw;
        logic bank_bg;
        tgt_e tgt;
        tco_e reg_sel;
    } dec_t;

endpackage

// File: rtl/cam_instr_decode.sv
module cam_instr_decode
    import cam_port_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic          en,
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    logic [CLS_W-1:0] cls;
    assign cls = instr[IW-1 -: CLS_W];

    always_comb begin
        dec         = '0;
        dec.tgt     = tgt_e'(instr[1:0]);
        dec.reg_sel = tco_e'(instr[2:0]);
        dec.bank_bg = instr[0];
        if (en) begin
            case (cls)
                OPC_SPS:  dec.sel_src = 1'b1;
                OPC_SPD:  dec.sel_dst = 1'b1;
                OPC_TCO: begin
                    if (instr[FLAG_BIT]) dec.tco_wr  = 1'b1;
                    else                 dec.tco_arm = 1'b1;
                end
                OPC_BANK: dec.bank_sw = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/cam_seg_counter.sv
module cam_seg_counter #(
    parameter int SEGS = 4,
    localparam int SEG_W = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [SEG_W-1:0] seg
);
    localparam logic [SEG_W-1:0] LAST = SEG_W'(SEGS - 1);

    logic [SEG_W-1:0] seg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seg_q <= '0;
        else if (clr)      seg_q <= '0;
        else if (adv)      seg_q <= (seg_q == LAST) ? '0 : seg_q + 1'b1;
    end

    assign seg = seg_q;
endmodule

// File: rtl/cam_cfg_bank.sv
module cam_cfg_bank
    import cam_port_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dec_t             dec,
    input  logic [REG_W-1:0] wval,
    output logic             bank_bg,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] segctl,
    output logic [REG_W-1:0] addr,
    output logic [REG_W-1:0] page,
    output logic [REG_W-1:0] devsel,
    output tgt_e             ps,
    output tgt_e             pd
);
    localparam int NBANK = 2;

    bank_state_e bank_q, bank_d;
    logic        bidx;

    logic [REG_W-1:0] ctrl_q   [NBANK];
    logic [REG_W-1:0] segctl_q [NBANK];
    logic [REG_W-1:0] addr_q   [NBANK];
    tgt_e             ps_q     [NBANK];
    tgt_e             pd_q     [NBANK];
    logic [REG_W-1:0] page_q, devsel_q;

    // bank state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_FG;
        else        bank_q <= bank_d;
    end

    // bank next state and outputs
    always_comb begin
        bank_d = bank_q;
        if (dec.bank_sw) bank_d = dec.bank_bg ? BANK_BG : BANK_FG;
        unique case (bank_q)
            BANK_FG: bidx = 1'b0;
            BANK_BG: bidx = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) begin
                ctrl_q[b]   <= '0;
                segctl_q[b] <= '0;
                addr_q[b]   <= '0;
                ps_q[b]     <= TGT_CMP;
                pd_q[b]     <= TGT_CMP;
            end
            page_q   <= '0;
            devsel_q <= '0;
        end else begin
            if (dec.sel_src) ps_q[bidx] <= dec.tgt;
            if (dec.sel_dst) pd_q[bidx] <= dec.tgt;
            if (dec.tco_wr) begin
                case (dec.reg_sel)
                    TCO_CTRL:   ctrl_q[bidx]   <= wval;
                    TCO_SEGCTL: segctl_q[bidx] <= wval;
                    TCO_ADDR:   addr_q[bidx]   <= wval;
                    TCO_PAGE:   page_q         <= wval;
                    TCO_DEVSEL: devsel_q       <= wval;
                    default:    ;
                endcase
            end
        end
    end

    assign bank_bg = bidx;
    assign ctrl    = ctrl_q[bidx];
    assign segctl  = segctl_q[bidx];
    assign addr    = addr_q[bidx];
    assign ps      = ps_q[bidx];
    assign pd      = pd_q[bidx];
    assign page    = page_q;
    assign devsel  = devsel_q;
endmodule

// File: rtl/cam_seg_regs.sv
module cam_seg_regs
    import cam_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEGS   = 4,
    localparam int WORD_W = DATA_W * SEGS,
    localparam int SEG_W  = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              wr_tgt,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bank,
    input  tgt_e              rd_tgt,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic [DATA_W-1:0] rd_word,
    output logic [WORD_W-1:0] cmp,
    output logic [WORD_W-1:0] msk1,
    output logic [WORD_W-1:0] msk2
);
    logic [WORD_W-1:0] cmp_q, m2_q;
    logic [WORD_W-1:0] m1_q [2];
    logic [WORD_W-1:0] rd_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            m2_q    <= '0;
            m1_q[0] <= '0;
            m1_q[1] <= '0;
        end else if (wr_en) begin
            case (wr_tgt)
                TGT_CMP:  cmp_q[wr_seg*DATA_W +: DATA_W]      <= wdata;
                TGT_MSK1: m1_q[bank][wr_seg*DATA_W +: DATA_W] <= wdata;
                TGT_MSK2: m2_q[wr_seg*DATA_W +: DATA_W]       <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_tgt)
            TGT_MSK1: rd_sel = m1_q[bank];
            TGT_MSK2: rd_sel = m2_q;
            default:  rd_sel = cmp_q;
        endcase
    end

    assign rd_word = rd_sel[rd_seg*DATA_W +: DATA_W];
    assign cmp     = cmp_q;
    assign msk1    = m1_q[bank];
    assign msk2    = m2_q;
endmodule

// File: rtl/cam_host_port.sv
module cam_host_port
    import cam_port_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEGS   = 4,
    localparam int REG_W  = DATA_W / 2,
    localparam int WORD_W = DATA_W * SEGS,
    localparam int SEG_W  = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_vld,
    input  logic              cyc_wr,
    input  logic              cyc_cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_vld,
    input  logic [DATA_W-1:0] status_in,
    input  logic [REG_W-1:0]  nfa_in,
    output logic [REG_W-1:0]  arr_addr,
    output logic              arr_wr_en,
    output logic [SEG_W-1:0]  arr_wr_seg,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_rd_en,
    output logic [SEG_W-1:0]  arr_rd_seg,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [WORD_W-1:0] cmp_data,
    output logic [WORD_W-1:0] msk1_data,
    output logic [WORD_W-1:0] msk2_data,
    output logic [REG_W-1:0]  ctrl_out,
    output logic              compare_trig
);
    localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(SEGS - 1);
    localparam int DIR_SRC = 0;
    localparam int DIR_DST = 1;

    logic data_rd, data_wr, cmd_rd, cmd_wr;
    assign data_rd = cyc_vld && !cyc_wr && !cyc_cmd;
    assign data_wr = cyc_vld &&  cyc_wr && !cyc_cmd;
    assign cmd_rd  = cyc_vld && !cyc_wr &&  cyc_cmd;
    assign cmd_wr  = cyc_vld &&  cyc_wr &&  cyc_cmd;

    // instruction decode
    dec_t dec;
    cam_instr_decode #(.IW(REG_W)) u_dec (
        .en    (cmd_wr),
        .instr (wdata[DATA_W-1 -: REG_W]),
        .dec   (dec)
    );

    // configuration banks
    logic             bank_bg;
    logic [REG_W-1:0] ctrl_v, segctl_v, addr_v, page_v, devsel_v;
    tgt_e             ps, pd;
    cam_cfg_bank #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wval    (wdata[REG_W-1:0]),
        .bank_bg (bank_bg),
        .ctrl    (ctrl_v),
        .segctl  (segctl_v),
        .addr    (addr_v),
        .page    (page_v),
        .devsel  (devsel_v),
        .ps      (ps),
        .pd      (pd)
    );

    // segment counters, one per direction
    logic [1:0]       cnt_clr, cnt_adv;
    logic [SEG_W-1:0] cnt_seg [2];
    assign cnt_clr[DIR_SRC] = dec.sel_src || dec.bank_sw;
    assign cnt_clr[DIR_DST] = dec.sel_dst || dec.bank_sw;
    assign cnt_adv[DIR_SRC] = data_rd;
    assign cnt_adv[DIR_DST] = data_wr;

    for (genvar d = 0; d < 2; d++) begin : g_cnt
        cam_seg_counter #(.SEGS(SEGS)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr[d]),
            .adv   (cnt_adv[d]),
            .seg   (cnt_seg[d])
        );
    end

    logic [SEG_W-1:0] src_seg, dst_seg;
    assign src_seg = cnt_seg[DIR_SRC];
    assign dst_seg = cnt_seg[DIR_DST];

    // 128-bit registers
    logic [DATA_W-1:0] reg_rd_word;
    cam_seg_regs #(.DATA_W(DATA_W), .SEGS(SEGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr && (pd != TGT_ARR)),
        .wr_tgt  (pd),
        .wr_seg  (dst_seg),
        .wdata   (wdata),
        .bank    (bank_bg),
        .rd_tgt  (ps),
        .rd_seg  (src_seg),
        .rd_word (reg_rd_word),
        .cmp     (cmp_data),
        .msk1    (msk1_data),
        .msk2    (msk2_data)
    );

    // array port
    assign arr_wr_en  = data_wr && (pd == TGT_ARR);
    assign arr_wr_seg = dst_seg;
    assign arr_wdata  = wdata;
    assign arr_rd_en  = data_rd && (ps == TGT_ARR);
    assign arr_rd_seg = src_seg;
    assign arr_addr   = addr_v;
    assign ctrl_out   = ctrl_v;

    // one-shot override state machine
    ovr_state_e ovr_q, ovr_d;
    tco_e       ovr_sel_q, ovr_sel_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q     <= OVR_IDLE;
            ovr_sel_q <= TCO_CTRL;
        end else begin
            ovr_q     <= ovr_d;
            ovr_sel_q <= ovr_sel_d;
        end
    end

    always_comb begin
        ovr_d     = ovr_q;
        ovr_sel_d = ovr_sel_q;
        unique case (ovr_q)
            OVR_IDLE: begin
                if (dec.tco_arm) begin
                    ovr_d     = OVR_ARMED;
                    ovr_sel_d = dec.reg_sel;
                end
            end
            OVR_ARMED: begin
                if (dec.tco_arm) begin
                    ovr_sel_d = dec.reg_sel;
                end else if (cmd_wr || cmd_rd) begin
                    ovr_d = OVR_IDLE;
                end
            end
        endcase
    end

    // override read value
    logic [REG_W-1:0]  ovr_reg;
    logic [DATA_W-1:0] cmd_rd_val;

    always_comb begin
        case (ovr_sel_q)
            TCO_CTRL:   ovr_reg = ctrl_v;
            TCO_PAGE:   ovr_reg = page_v;
            TCO_SEGCTL: ovr_reg = segctl_v;
            TCO_ADDR:   ovr_reg = addr_v;
            TCO_NFA:    ovr_reg = nfa_in;
            TCO_DEVSEL: ovr_reg = devsel_v;
            TCO_PS:     ovr_reg = {{(REG_W-2){1'b0}}, ps};
            default:    ovr_reg = {{(REG_W-2){1'b0}}, pd};
        endcase
    end

    always_comb begin
        unique case (ovr_q)
            OVR_IDLE:  cmd_rd_val = status_in;
            OVR_ARMED: begin
                if (ovr_sel_q == TCO_PAGE) cmd_rd_val = {{REG_W{1'b0}}, ovr_reg};
                else cmd_rd_val = {status_in[DATA_W-1 -: REG_W], ovr_reg};
            end
        endcase
    end

    // read data and compare trigger registers
    logic [DATA_W-1:0] rdata_q;
    logic              rd_vld_q, trig_q, trig_d;

    assign trig_d = (dec.tco_wr && dec.reg_sel == TCO_CTRL)
                 || (data_wr && pd != TGT_ARR && dst_seg == LAST_SEG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rd_vld_q <= 1'b0;
            trig_q   <= 1'b0;
        end else begin
            rd_vld_q <= data_rd || cmd_rd;
            trig_q   <= trig_d;
            if (data_rd)     rdata_q <= (ps == TGT_ARR) ? arr_rdata : reg_rd_word;
            else if (cmd_rd) rdata_q <= cmd_rd_val;
        end
    end

    assign rdata        = rdata_q;
    assign rd_vld       = rd_vld_q;
    assign compare_trig = trig_q;
endmodule

// File: rtl/cam_host_port_chk.sv
module cam_host_port_chk #(
    parameter int DATA_W = 32,
    parameter int SEGS   = 4,
    localparam int REG_W  = DATA_W / 2,
    localparam int WORD_W = DATA_W * SEGS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_vld,
    input logic              cyc_wr,
    input logic              cyc_cmd,
    input logic              rd_vld,
    input logic              compare_trig,
    input logic              arr_wr_en,
    input logic              arr_rd_en,
    input logic [REG_W-1:0]  arr_addr,
    input logic [WORD_W-1:0] cmp_data,
    input logic [WORD_W-1:0] msk2_data,
    input logic [REG_W-1:0]  ctrl_out
);
    AST_RDVLD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(cyc_vld && !cyc_wr)); // R3

    AST_TRIG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        compare_trig |-> $past(cyc_vld && cyc_wr)); // R10

    AST_ARR_WR_ON_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (cyc_vld && cyc_wr && !cyc_cmd)); // R5

    AST_ARR_RD_ON_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |-> (cyc_vld && !cyc_wr && !cyc_cmd)); // R5

    AST_ARR_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr_en, arr_rd_en})); // R5

    AST_CMP_HELD_WITHOUT_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_vld && cyc_wr && !cyc_cmd) |=> $stable(cmp_data)); // R2

    AST_MSK2_HELD_WITHOUT_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_vld && cyc_wr && !cyc_cmd) |=> $stable(msk2_data)); // R2

    AST_CTRL_HELD_WITHOUT_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_vld && cyc_wr && cyc_cmd) |=> $stable(ctrl_out)); // R7

    AST_ADDR_HELD_WITHOUT_CMD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_vld && cyc_wr && cyc_cmd) |=> $stable(arr_addr)); // R9
endmodule

bind cam_host_port cam_host_port_chk #(.DATA_W(DATA_W), .SEGS(SEGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_vld      (cyc_vld),
    .cyc_wr       (cyc_wr),
    .cyc_cmd      (cyc_cmd),
    .rd_vld       (rd_vld),
    .compare_trig (compare_trig),
    .arr_wr_en    (arr_wr_en),
    .arr_rd_en    (arr_rd_en),
    .arr_addr     (arr_addr),
    .cmp_data     (cmp_data),
    .msk2_data    (msk2_data),
    .ctrl_out     (ctrl_out)
);

// File: tb/cam_host_port_tb.sv
module cam_host_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] STATUS = 32'hBEEF_1234;
    localparam logic [15:0] NFA    = 16'h0ABC;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_vld = 1'b0, cyc_wr = 1'b0, cyc_cmd = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         rd_vld;
    logic [15:0]  arr_addr;
    logic         arr_wr_en, arr_rd_en;
    logic [1:0]   arr_wr_seg, arr_rd_seg;
    logic [31:0]  arr_wdata, arr_rdata;
    logic [127:0] cmp_data, msk1_data, msk2_data;
    logic [15:0]  ctrl_out;
    logic         compare_trig;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] arr_fn(input logic [1:0] s);
        return {16'hA5C3, 14'h0, s};
    endfunction
    assign arr_rdata = arr_fn(arr_rd_seg);

    cam_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_wr(cyc_wr), .cyc_cmd(cyc_cmd),
        .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld), .status_in(STATUS), .nfa_in(NFA),
        .arr_addr(arr_addr), .arr_wr_en(arr_wr_en), .arr_wr_seg(arr_wr_seg),
        .arr_wdata(arr_wdata), .arr_rd_en(arr_rd_en), .arr_rd_seg(arr_rd_seg),
        .arr_rdata(arr_rdata), .cmp_data(cmp_data), .msk1_data(msk1_data),
        .msk2_data(msk2_data), .ctrl_out(ctrl_out), .compare_trig(compare_trig)
    );

    // reference model state
    logic [127:0] m_cmp, m_m2;
    logic [127:0] m_m1 [2];
    logic [1:0]   m_ps [2], m_pd [2];
    logic [15:0]  m_ctrl [2], m_segc [2], m_addr [2];
    logic [15:0]  m_page, m_dev;
    int           m_bank, m_sc, m_dc;
    bit           m_armed;
    logic [2:0]   m_asel;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [3:0] cls, input bit f,
                                        input logic [2:0] sel, input logic [15:0] v);
        return {cls, f, 8'h00, sel, v};
    endfunction

    function automatic logic [15:0] m_reg(input logic [2:0] s);
        case (s)
            3'd0: return m_ctrl[m_bank];
            3'd1: return m_page;
            3'd2: return m_segc[m_bank];
            3'd3: return m_addr[m_bank];
            3'd4: return NFA;
            3'd5: return m_dev;
            3'd6: return {14'h0, m_ps[m_bank]};
            default: return {14'h0, m_pd[m_bank]};
        endcase
    endfunction

    function automatic logic [31:0] m_seg_rd(input logic [1:0] t, input int k);
        logic [127:0] w;
        case (t)
            2'd0: w = m_cmp;
            2'd1: w = m_m1[m_bank];
            default: w = m_m2;
        endcase
        return w[32*k +: 32];
    endfunction

    task automatic model_reset();
        m_cmp = '0; m_m2 = '0; m_page = '0; m_dev = '0;
        for (int b = 0; b < 2; b++) begin
            m_m1[b] = '0; m_ps[b] = '0; m_pd[b] = '0;
            m_ctrl[b] = '0; m_segc[b] = '0; m_addr[b] = '0;
        end
        m_bank = 0; m_sc = 0; m_dc = 0; m_armed = 0; m_asel = '0;
    endtask

    // one host cycle: predict, drive, compare
    task automatic run(input logic wr, input logic cmd, input logic [31:0] wd, input string tag);
        logic [31:0] er = '0;
        bit isrd = !wr, et = 0, earw = 0, earr = 0;
        int eseg = 0;
        logic [3:0] cls = wd[31:28];
        logic [2:0] sel = wd[18:16];
        logic s_aw, s_ar;
        logic [1:0] s_aws, s_ars;
        logic [31:0] s_awd;
        if (!cmd && wr) begin
            logic [1:0] t = m_pd[m_bank];
            if (t == 2'd3) begin earw = 1; eseg = m_dc; end
            else begin
                case (t)
                    2'd0: m_cmp[32*m_dc +: 32] = wd;
                    2'd1: m_m1[m_bank][32*m_dc +: 32] = wd;
                    default: m_m2[32*m_dc +: 32] = wd;
                endcase
                et = (m_dc == 3);
            end
            m_dc = (m_dc + 1) % 4;
        end else if (!cmd) begin
            logic [1:0] t = m_ps[m_bank];
            if (t == 2'd3) begin earr = 1; eseg = m_sc; er = arr_fn(2'(m_sc)); end
            else er = m_seg_rd(t, m_sc);
            m_sc = (m_sc + 1) % 4;
        end else if (wr) begin
            m_armed = 0;
            case (cls)
                4'd1: begin m_ps[m_bank] = sel[1:0]; m_sc = 0; end
                4'd2: begin m_pd[m_bank] = sel[1:0]; m_dc = 0; end
                4'd3: begin
                    if (wd[27]) begin
                        case (sel)
                            3'd0: begin m_ctrl[m_bank] = wd[15:0]; et = 1; end
                            3'd1: m_page = wd[15:0];
                            3'd2: m_segc[m_bank] = wd[15:0];
                            3'd3: m_addr[m_bank] = wd[15:0];
                            3'd5: m_dev = wd[15:0];
                            default: ;
                        endcase
                    end else begin m_armed = 1; m_asel = sel; end
                end
                4'd4: begin m_bank = int'(wd[16]); m_sc = 0; m_dc = 0; end
                default: ;
            endcase
        end else begin
            if (m_armed) er = {(m_asel == 3'd1) ? 16'h0 : STATUS[31:16], m_reg(m_asel)};
            else er = STATUS;
            m_armed = 0;
        end

        @(negedge clk);
        cyc_vld = 1'b1; cyc_wr = wr; cyc_cmd = cmd; wdata = wd;
        #1;
        s_aw = arr_wr_en; s_aws = arr_wr_seg; s_awd = arr_wdata;
        s_ar = arr_rd_en; s_ars = arr_rd_seg;
        @(posedge clk);
        #1;
        cyc_vld = 1'b0;

        chk({tag, " R5 arr_wr_en"}, s_aw, earw);
        chk({tag, " R5 arr_rd_en"}, s_ar, earr);
        if (earw) begin
            chk({tag, " R5 arr_wr_seg"}, s_aws, eseg);
            chk({tag, " R5 arr_wdata"}, s_awd, wd);
        end
        if (earr) chk({tag, " R5 arr_rd_seg"}, s_ars, eseg);
        chk({tag, " rd_vld"}, rd_vld, isrd);
        if (isrd) chk({tag, " rdata"}, rdata, er);
        chk({tag, " R10 compare_trig"}, compare_trig, et);
        chk({tag, " R2 cmp_data"}, cmp_data, m_cmp);
        chk({tag, " R9 msk1_data"}, msk1_data, m_m1[m_bank]);
        chk({tag, " R2 msk2_data"}, msk2_data, m_m2);
        chk({tag, " R9 ctrl_out"}, ctrl_out, m_ctrl[m_bank]);
        chk({tag, " R9 arr_addr"}, arr_addr, m_addr[m_bank]);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(7321));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 rd_vld", rd_vld, 0);
        chk("R1 rdata", rdata, 0);
        chk("R1 compare_trig", compare_trig, 0);
        chk("R1 cmp_data", cmp_data, 0);
        chk("R1 ctrl_out", ctrl_out, 0);
        @(negedge clk); rst_n = 1'b1;

        run(1, 1, ins(4'd3, 0, 3'd6, 0), "R1 arm PS");
        run(0, 1, 32'h0, "R1 PS read");
        // R2, R10: comparand fill; trigger only on segment 3
        for (int k = 0; k < 4; k++) run(1, 0, 32'h1111_0000 + k, "R2 cmp write");
        run(1, 0, 32'hCAFE_0004, "R2 cmp wrap");
        // R3: reads wrap from 3 to 0
        for (int k = 0; k < 6; k++) run(0, 0, 0, "R3 cmp read");
        // R4: destination mask 2, source stays comparand
        run(1, 1, ins(4'd2, 0, 3'd2, 0), "R4 SPD mask2");
        for (int k = 0; k < 4; k++) run(1, 0, 32'h2222_0000 + k, "R4 mask2 write");
        run(0, 0, 0, "R4 source unchanged");
        run(1, 1, ins(4'd1, 0, 3'd2, 0), "R4 SPS mask2");
        run(0, 0, 0, "R4 source counter cleared");
        // R5, R7: array path with address
        run(1, 1, ins(4'd3, 1, 3'd3, 16'h0123), "R7 addr write");
        run(1, 1, ins(4'd2, 0, 3'd3, 0), "R5 SPD array");
        run(1, 0, 32'hDEAD_BEEF, "R5 array write");
        run(1, 1, ins(4'd1, 0, 3'd3, 0), "R5 SPS array");
        run(0, 0, 0, "R5 array read");
        run(0, 0, 0, "R5 array read");
        // R6, R7, R8
        run(0, 1, 0, "R6 status read");
        run(1, 1, ins(4'd3, 1, 3'd0, 16'h00F1), "R7 ctrl write");
        run(1, 1, ins(4'd3, 1, 3'd1, 16'h7777), "R7 page write");
        run(1, 1, ins(4'd3, 0, 3'd1, 0), "R8 arm page");
        run(0, 0, 0, "R8 data read while armed");
        run(0, 1, 0, "R8 page read");
        run(0, 1, 0, "R8 lapsed");
        run(1, 1, ins(4'd3, 0, 3'd4, 0), "R8 arm nfa");
        run(1, 1, ins(4'd0, 0, 3'd0, 0), "R8 cancel");
        run(0, 1, 0, "R8 cancelled read");
        // R11: read-only codes and unused classes
        run(1, 1, ins(4'd3, 1, 3'd6, 16'h0001), "R11 PS write ignored");
        run(1, 1, ins(4'd9, 1, 3'd0, 16'hFFFF), "R11 unused class");
        run(1, 1, ins(4'd3, 0, 3'd6, 0), "R11 arm PS");
        run(0, 1, 0, "R11 PS read");
        // R9: background bank
        run(1, 1, ins(4'd4, 0, 3'd1, 0), "R9 to background");
        run(1, 1, ins(4'd3, 0, 3'd7, 0), "R9 arm PD");
        run(0, 1, 0, "R9 bg PD is comparand");
        run(1, 1, ins(4'd2, 0, 3'd1, 0), "R9 bg SPD mask1");
        for (int k = 0; k < 4; k++) run(1, 0, 32'h3333_0000 + k, "R9 bg mask1 write");
        run(1, 1, ins(4'd4, 0, 3'd0, 0), "R9 to foreground");
        run(1, 0, 32'h4444_0000, "R9 fg destination array");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 11);
            logic [2:0] s = 3'($urandom_range(0, 7));
            logic [15:0] v = 16'($urandom);
            case (r)
                0, 1, 2: run(1, 0, $urandom, "R2 rnd data write");
                3, 4:    run(0, 0, 0, "R3 rnd data read");
                5:       run(1, 1, ins(4'd1, 0, s, 0), "R4 rnd SPS");
                6:       run(1, 1, ins(4'd2, 0, s, 0), "R4 rnd SPD");
                7:       run(1, 1, ins(4'd3, 1, s, v), "R7 rnd TCO write");
                8:       run(1, 1, ins(4'd3, 0, s, 0), "R8 rnd arm");
                9:       run(0, 1, 0, "R6 rnd cmd read");
                10:      run(1, 1, ins(4'd4, 0, s, 0), "R9 rnd bank");
                default: run(1, 1, ins(4'($urandom_range(5, 15)), 1, s, v), "R11 rnd unused");
            endcase
        end

        summary();
        $finish;
    end
endmodule